// File: doc/BRIEF.md
# XT-Class Bus Cycle Sequencer

This block is a bus master that performs single 8-bit memory or I/O transfers on an XT-class system bus. A client raises a start request with a 20-bit address, a space select (memory or I/O), a direction flag and a write byte. The sequencer then steps the bus through the standard clock states and returns a one-clock completion pulse. For reads, the completion pulse comes with the byte that was captured.

On the bus side the sequencer drives the address latch enable, the held address, the four active-low command strobes and the write data with its output enable. A slow target can hold the ready input low at the end of the third state. Each low sample then adds one wait state, and the command stays asserted until the target releases ready. Every bus output is a register, so the bus sees no combinational glitches.

Top module: `xt_bus_sequencer`

## Requirements
- R1: After a synchronous reset, all four strobes are high, ALE is low, the data output enable is low and the done pulse is low.
- R2: In the first clock after an accepted start (T1), ALE is high, all strobes are high, and the bus address equals the requested address.
- R3: In T2 and T3, ALE is low and the selected strobe is low. A cycle without waits asserts the strobe for exactly two clocks.
- R4: The strobe is chosen by {io_select, write}: 00 selects memory read, 01 memory write, 10 I/O read and 11 I/O write. At no time is more than one strobe low.
- R5: Ready is sampled on the clock edge that ends T3 and on the edge that ends each wait state. Each low sample adds one wait state with the strobe still low. The strobe therefore stays low for 2+N clocks, where N is the number of consecutive low samples.
- R6: T4 follows the first high ready sample, with the strobe high. The done pulse is high for exactly the one clock after T4, which is 4+N clocks after the first T1 clock.
- R7: Read data is the bus input value present at the edge of the high ready sample. It is presented on the read data output while done is high.
- R8: For writes, the output enable is high and the write byte is on the data outputs from T2 through T4. The enable is low in T1, in idle and during any read.
- R9: A start request that is held during a running cycle is ignored. No ALE appears again until a start is seen while idle.
- R10: The bus address holds the requested value unchanged from T1 through T4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Start a transfer (accepted only while idle) |
| req_addr | input | 20 | Transfer address |
| req_is_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_is_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write byte |
| rsp_rdata | output | 8 | Captured read byte |
| rsp_done | output | 1 | One-clock completion pulse |
| bus_ale | output | 1 | Address latch enable |
| bus_addr | output | 20 | Bus address |
| bus_memr_n | output | 1 | Memory read strobe, active low |
| bus_memw_n | output | 1 | Memory write strobe, active low |
| bus_ior_n | output | 1 | I/O read strobe, active low |
| bus_iow_n | output | 1 | I/O write strobe, active low |
| bus_dout | output | 8 | Write data toward the bus |
| bus_dout_en | output | 1 | Write data output enable |
| bus_din | input | 8 | Read data from the bus |
| bus_rdy | input | 1 | Target ready, low requests wait states |

## Verification
A sequencer that enters the wrong state shows it at the strobes within one clock. A skipped or extra state changes the count of strobe-low clocks, and a stuck wait state keeps the strobe low past the point where ready went high. A wrong latched select lights the wrong strobe on the first T2 clock. A capture on the wrong edge returns the decoy byte that the bench drives on the other wait clocks, and this shows when done rises. The bench compares every output on every clock of every transfer against a timeline built from the request and the ready pattern, so any such error is reported on the clock where it first appears.

// File: rtl/xtb_pkg.sv
package xtb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5
  } bus_st_t;

  localparam int STB_CNT = 4;
  localparam int SEL_W   = $clog2(STB_CNT);
endpackage

// File: rtl/xtb_fsm.sv
module xtb_fsm
  import xtb_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    rdy,
  output bus_st_t st_q,
  output bus_st_t st_d,
  output logic    accept,
  output logic    capture,
  output logic    done
);
  logic sampling;

  assign sampling = (st_q == ST_T3) || (st_q == ST_TW);
  assign accept   = (st_q == ST_IDLE) && start;
  assign capture  = sampling && rdy;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:      if (start) st_d = ST_T1;
      ST_T1:        st_d = ST_T2;
      ST_T2:        st_d = ST_T3;
      ST_T3, ST_TW: st_d = rdy ? ST_T4 : ST_TW;
      ST_T4:        st_d = ST_IDLE;
      default:      st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE;
      done <= 1'b0;
    end else begin
      st_q <= st_d;
      done <= (st_q == ST_T4);
    end
  end

  // R5
  wait_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (sampling && !rdy) |=> (st_q == ST_TW));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_IDLE) |=> (st_q != ST_T1));
endmodule

// File: rtl/xtb_datapath.sv
module xtb_datapath
  import xtb_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_is_io,
  input  logic              in_is_write,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic [DATA_W-1:0] bus_din,
  output logic [ADDR_W-1:0] addr_q,
  output logic [SEL_W-1:0]  sel_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      sel_q   <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        addr_q  <= in_addr;
        sel_q   <= {in_is_io, in_is_write};
        wdata_q <= in_wdata;
      end
      if (capture) rdata_q <= bus_din;
    end
  end
endmodule

// File: rtl/xtb_ctl_reg.sv
module xtb_ctl_reg
  import xtb_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  bus_st_t            st_d,
  input  logic [SEL_W-1:0]   sel,
  output logic               ale,
  output logic [STB_CNT-1:0] stb_n,
  output logic               dout_en
);
  logic cmd_on;
  logic drv_on;
  logic [STB_CNT-1:0] stb_n_d;

  assign cmd_on = (st_d == ST_T2) || (st_d == ST_T3) || (st_d == ST_TW);
  assign drv_on = cmd_on || (st_d == ST_T4);

  for (genvar k = 0; k < STB_CNT; k++) begin : g_stb
    assign stb_n_d[k] = !(cmd_on && (sel == SEL_W'(k)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ale     <= 1'b0;
      stb_n   <= '1;
      dout_en <= 1'b0;
    end else begin
      ale     <= (st_d == ST_T1);
      stb_n   <= stb_n_d;
      dout_en <= drv_on && sel[0];
    end
  end

  // R4
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(~stb_n) <= 1);

  // R2
  ale_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ale |-> (&stb_n));
endmodule

// File: rtl/xt_bus_sequencer.sv
module xt_bus_sequencer
  import xtb_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_start,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_is_io,
  input  logic              req_is_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_done,
  output logic              bus_ale,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_memr_n,
  output logic              bus_memw_n,
  output logic              bus_ior_n,
  output logic              bus_iow_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_dout_en,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              bus_rdy
);
  bus_st_t            st_q;
  bus_st_t            st_d;
  logic               accept;
  logic               capture;
  logic [SEL_W-1:0]   sel_q;
  logic [STB_CNT-1:0] stb_n;

  xtb_fsm i_fsm (
    .clk     (clk),
    .rst     (rst),
    .start   (req_start),
    .rdy     (bus_rdy),
    .st_q    (st_q),
    .st_d    (st_d),
    .accept  (accept),
    .capture (capture),
    .done    (rsp_done)
  );

  xtb_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk         (clk),
    .rst         (rst),
    .accept      (accept),
    .capture     (capture),
    .in_addr     (req_addr),
    .in_is_io    (req_is_io),
    .in_is_write (req_is_write),
    .in_wdata    (req_wdata),
    .bus_din     (bus_din),
    .addr_q      (bus_addr),
    .sel_q       (sel_q),
    .wdata_q     (bus_dout),
    .rdata_q     (rsp_rdata)
  );

  xtb_ctl_reg i_ctl (
    .clk     (clk),
    .rst     (rst),
    .st_d    (st_d),
    .sel     (sel_q),
    .ale     (bus_ale),
    .stb_n   (stb_n),
    .dout_en (bus_dout_en)
  );

  assign bus_memr_n = stb_n[0];
  assign bus_memw_n = stb_n[1];
  assign bus_ior_n  = stb_n[2];
  assign bus_iow_n  = stb_n[3];

  // R8
  oe_read_chk: assert property (@(posedge clk) disable iff (rst)
    bus_dout_en |-> (bus_memr_n && bus_ior_n && !bus_ale));

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_ale && (st_q != ST_IDLE)) |-> $stable(bus_addr));

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> (&stb_n));
endmodule

// File: tb/test_xt_bus_sequencer.sv
`timescale 1ns/1ps
module test_xt_bus_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_start = 1'b0;
  logic [19:0] req_addr = '0;
  logic        req_is_io = 1'b0;
  logic        req_is_write = 1'b0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  rsp_rdata;
  logic        rsp_done;
  logic        bus_ale;
  logic [19:0] bus_addr;
  logic        bus_memr_n, bus_memw_n, bus_ior_n, bus_iow_n;
  logic [7:0]  bus_dout;
  logic        bus_dout_en;
  logic [7:0]  bus_din = '0;
  logic        bus_rdy = 1'b1;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  xt_bus_sequencer i_xt_bus_sequencer (
    .clk(clk), .rst(rst), .req_start(req_start), .req_addr(req_addr),
    .req_is_io(req_is_io), .req_is_write(req_is_write), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .bus_ale(bus_ale),
    .bus_addr(bus_addr), .bus_memr_n(bus_memr_n), .bus_memw_n(bus_memw_n),
    .bus_ior_n(bus_ior_n), .bus_iow_n(bus_iow_n), .bus_dout(bus_dout),
    .bus_dout_en(bus_dout_en), .bus_din(bus_din), .bus_rdy(bus_rdy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // strobe vector {iow,ior,memw,memr}; active bit index = {io,write}
  function automatic logic [3:0] exp_stb(input bit on, input bit io, input bit wr);
    logic [3:0] v;
    v = 4'hF;
    if (on) v[{io, wr}] = 1'b0;
    return v;
  endfunction

  task automatic run_xfer(input bit io, input bit wr, input logic [19:0] a,
                          input logic [7:0] wd, input int nw, input bit hold);
    logic [7:0] rd;
    int last;
    rd = 8'($urandom);
    last = 5 + nw;
    req_start = 1'b1; req_addr = a; req_is_io = io;
    req_is_write = wr; req_wdata = wd;
    @(posedge clk); @(negedge clk);
    if (!hold) req_start = 1'b0;
    req_addr = ~a; req_wdata = ~wd;
    for (int c = 1; c <= last; c++) begin
      bit stb_on;
      if (c >= 3 && c <= 3 + nw) begin
        bus_rdy = (c - 3 >= nw);
        bus_din = (c == 3 + nw) ? rd : ~rd;
      end else begin
        bus_rdy = 1'b1;
        bus_din = ~rd;
      end
      stb_on = (c >= 2 && c <= 3 + nw);
      chk(c == 1 ? "R2 ale" : "R3 ale", 32'(bus_ale), 32'(c == 1));
      chk(nw > 0 ? "R5 strobes" : "R4 strobes",
          32'({bus_iow_n, bus_ior_n, bus_memw_n, bus_memr_n}),
          32'(exp_stb(stb_on, io, wr)));
      chk("R8 oe", 32'(bus_dout_en), 32'(wr && c >= 2 && c <= 4 + nw));
      if (wr && c >= 2 && c <= 4 + nw) chk("R8 wdata", 32'(bus_dout), 32'(wd));
      if (c <= 4 + nw) chk("R10 addr", 32'(bus_addr), 32'(a));
      chk("R6 done", 32'(rsp_done), 32'(c == last));
      if (c == last) begin
        req_start = 1'b0;
        if (!wr) chk("R7 rdata", 32'(rsp_rdata), 32'(rd));
      end
      @(posedge clk); @(negedge clk);
    end
    chk("R9 no relaunch ale", 32'(bus_ale), 32'd0);
    chk("R9 done low", 32'(rsp_done), 32'd0);
  endtask

  initial begin
    void'($urandom(1841));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 strobes", 32'({bus_iow_n, bus_ior_n, bus_memw_n, bus_memr_n}), 32'hF);
    chk("R1 ale", 32'(bus_ale), 32'd0);
    chk("R1 oe", 32'(bus_dout_en), 32'd0);
    chk("R1 done", 32'(rsp_done), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    // R4 every select code, no waits
    run_xfer(1'b0, 1'b0, 20'hA5123, 8'h3C, 0, 1'b0);
    run_xfer(1'b0, 1'b1, 20'h00001, 8'hC3, 0, 1'b0);
    run_xfer(1'b1, 1'b0, 20'h003F5, 8'h11, 0, 1'b0);
    run_xfer(1'b1, 1'b1, 20'hFFFFF, 8'hEE, 0, 1'b0);
    // R5 wait states
    run_xfer(1'b0, 1'b0, 20'h12345, 8'h00, 1, 1'b0);
    run_xfer(1'b1, 1'b1, 20'h54321, 8'h5A, 5, 1'b0);
    // R9 start held throughout
    run_xfer(1'b0, 1'b1, 20'h0BEEF, 8'h77, 2, 1'b1);
    run_xfer(1'b1, 1'b0, 20'h00060, 8'h99, 0, 1'b1);
    for (int i = 0; i < 40; i++) begin
      run_xfer(1'($urandom), 1'($urandom), 20'($urandom), 8'($urandom),
               int'($urandom_range(0, 7)), 1'($urandom));
      repeat (int'($urandom_range(0, 2))) @(negedge clk);
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule